// File: doc/BRIEF.md
# Bit-level I2C master engine

This block is the wire-level half of an I2C controller. It owns the SCL output and an SDA line with separate drive-enable and drive-value outputs. It carries out one bus command at a time: a START condition, a STOP condition, a byte sent out, a byte read in, or an address byte built from a 7-bit device address and a read/write flag. Every phase of the bus waveform lasts a whole number of timer ticks. A tick is `TICK_CYCLES` clock cycles, which defaults to 80 ns at a 5 ns clock. Each phase length comes from a nanosecond value using ticks = ns*125/10000, truncated.

The caller presents a command together with `cmdValid` while the engine is idle. It then waits for a one-cycle `done` pulse. After a sent byte, `ackErr` holds the acknowledge bit returned by the target. After a received byte, `rxByte` holds the assembled byte. The master releases SDA whenever it lowers SCL after a clock-high phase, so master and target never drive SDA at the same time. STOP finishes by releasing SDA to the external pull-up. The input `fastMode` selects the fast timing set (1) or the standard timing set (0).

Top module: `i2cBitMaster`

## Requirements
- R1: After reset, `scl` is 1, `sdaOe` is 0 and `busy` is 0.
- R2: START (cmdOp=0) drives SDA high with SCL high and waits the start setup time. It then drives SDA low while SCL stays high. After the start hold time (fast 7 ticks, standard 50 ticks) it lowers SCL and keeps SDA driven low.
- R3: STOP (cmdOp=1) drives SDA low, waits 11 ticks, then raises SCL. After the stop setup time it releases SDA (`sdaOe`=0) while SCL is high. It completes with SCL high and SDA released.
- R4: Send byte (cmdOp=2) shifts `cmdData` out MSB first, one bit per SCL pulse, and then reads a ninth bit from SDA. `ackErr` is 1 when that ninth bit was 1 (no acknowledge) and 0 otherwise.
- R5: Every SCL fall that ends a data or acknowledge clock-high phase sets `sdaOe` to 0 on the same clock edge.
- R6: Receive byte (cmdOp=3) samples SDA at the end of each of 8 clock-high phases and assembles `rxByte` MSB first. It then drives a ninth bit: 1 when `cmdLast` was 1, 0 otherwise.
- R7: Address byte (cmdOp=4) sends {cmdData[6:0], cmdRead} as a send byte, so bit 0 is 1 for a read and 0 for a write.
- R8: A phase of N ticks lasts exactly N*TICK_CYCLES clock cycles. The data and acknowledge clock-high time is 7 ticks in fast mode (600 ns) and 50 ticks in standard mode (4000 ns).
- R9: An accepted command raises `busy` on the next cycle. `done` is a one-cycle pulse on the cycle `busy` falls. A command presented while busy is ignored.
- R10: Command codes 5 to 7 are ignored: `busy` stays 0 and the bus lines do not move.
- R11: `fastMode`=1 selects 1300/600/100/600/600/600/1300 ns for clock low, clock high, data setup, start hold, start setup, stop setup and bus idle. `fastMode`=0 selects 4700/4000/250/4000/4700/4000/4700 ns. Both sets wait 900 ns from releasing or lowering SDA to the next SCL rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastMode | input | 1 | 1 = fast timing set, 0 = standard timing set |
| cmdValid | input | 1 | Command request, taken only while idle |
| cmdOp | input | 3 | 0 start, 1 stop, 2 send byte, 3 receive byte, 4 address byte |
| cmdData | input | 8 | Byte to send; bits 6:0 form the address for cmdOp 4 |
| cmdRead | input | 1 | Read/write flag for the address byte (1 = read) |
| cmdLast | input | 1 | Receive byte: answer with NACK instead of ACK |
| sdaIn | input | 1 | Sampled level of the SDA wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | 8 | Last byte received |
| ackErr | output | 1 | Acknowledge bit read after the last sent byte |
| scl | output | 1 | Clock line level |
| sdaOe | output | 1 | SDA drive enable |
| sdaOut | output | 1 | SDA drive value when enabled |

## Verification
The hardest case to reach is a command that arrives while another one is running. A second request must be ignored, yet its data could still corrupt the shift register mid-byte. The stimulus raises `cmdValid` with different data partway through a send byte. It then checks the serial stream captured on the wire. A target model reads SCL and pulls the wire low according to a per-command bit pattern. This lets NACK, ACK and arbitrary read data reach the sampling points exactly as a real target would present them.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_SEND  = 3'd2,
    OP_RECV  = 3'd3,
    OP_ADDR  = 3'd4
  } op_e;

  // which wait the phase timer should run
  typedef enum logic [3:0] {
    W_LOW, W_HIGH, W_SETUP, W_SHOLD, W_SSETUP, W_PSETUP, W_IDLE, W_C2D, W_RXLOW
  } wait_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TX   = 2'd2
  } sdaSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    sclRise;
    logic    sclFall;
    logic    sdaDrv;
    sdaSrc_e sdaSrc;
    logic    sdaRel;
    logic    loadTx;
    logic    loadAddr;
    logic    txShift;
    logic    armRx;
    logic    rxSample;
    logic    ackSample;
    logic    loadAckOut;
    logic    cntClr;
    logic    cntInc;
  } strobe_t;

  // nanosecond figures of both timing sets
  localparam int FAST_LOW_NS    = 1300;
  localparam int FAST_HIGH_NS   = 600;
  localparam int FAST_SETUP_NS  = 100;
  localparam int FAST_SHOLD_NS  = 600;
  localparam int FAST_SSETUP_NS = 600;
  localparam int FAST_PSETUP_NS = 600;
  localparam int FAST_IDLE_NS   = 1300;
  localparam int STD_LOW_NS     = 4700;
  localparam int STD_HIGH_NS    = 4000;
  localparam int STD_SETUP_NS   = 250;
  localparam int STD_SHOLD_NS   = 4000;
  localparam int STD_SSETUP_NS  = 4700;
  localparam int STD_PSETUP_NS  = 4000;
  localparam int STD_IDLE_NS    = 4700;
  localparam int C2D_NS         = 900;

  // 80 ns tick: ns * 125 / 10000, truncated
  function automatic int nsToTicks(input int ns);
    return (ns * 125) / 10000;
  endfunction

endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer
  import i2cm_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int CNT_W       = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  load,
  input  wait_e sel,
  input  logic  fastMode,
  output logic  expired
);

  localparam int F_LOW    = nsToTicks(FAST_LOW_NS);
  localparam int F_HIGH   = nsToTicks(FAST_HIGH_NS);
  localparam int F_SETUP  = nsToTicks(FAST_SETUP_NS);
  localparam int F_SHOLD  = nsToTicks(FAST_SHOLD_NS);
  localparam int F_SSETUP = nsToTicks(FAST_SSETUP_NS);
  localparam int F_PSETUP = nsToTicks(FAST_PSETUP_NS);
  localparam int F_IDLE   = nsToTicks(FAST_IDLE_NS);
  localparam int F_RXLOW  = nsToTicks(FAST_LOW_NS - C2D_NS);
  localparam int S_LOW    = nsToTicks(STD_LOW_NS);
  localparam int S_HIGH   = nsToTicks(STD_HIGH_NS);
  localparam int S_SETUP  = nsToTicks(STD_SETUP_NS);
  localparam int S_SHOLD  = nsToTicks(STD_SHOLD_NS);
  localparam int S_SSETUP = nsToTicks(STD_SSETUP_NS);
  localparam int S_PSETUP = nsToTicks(STD_PSETUP_NS);
  localparam int S_IDLE   = nsToTicks(STD_IDLE_NS);
  localparam int S_RXLOW  = nsToTicks(STD_LOW_NS - C2D_NS);
  localparam int C2D      = nsToTicks(C2D_NS);

  int ticks;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt;
  logic running;

  always_comb begin
    case (sel)
      W_LOW:    ticks = fastMode ? F_LOW    : S_LOW;
      W_HIGH:   ticks = fastMode ? F_HIGH   : S_HIGH;
      W_SETUP:  ticks = fastMode ? F_SETUP  : S_SETUP;
      W_SHOLD:  ticks = fastMode ? F_SHOLD  : S_SHOLD;
      W_SSETUP: ticks = fastMode ? F_SSETUP : S_SSETUP;
      W_PSETUP: ticks = fastMode ? F_PSETUP : S_PSETUP;
      W_IDLE:   ticks = fastMode ? F_IDLE   : S_IDLE;
      W_RXLOW:  ticks = fastMode ? F_RXLOW  : S_RXLOW;
      default:  ticks = C2D;
    endcase
    span = CNT_W'(ticks * TICK_CYCLES - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= span;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdRead,
  input  logic              cmdLast,
  input  logic              sdaIn,
  output logic              scl,
  output logic              sdaOe,
  output logic              sdaOut,
  output logic [BYTE_W-1:0] rxByte,
  output logic              ackErr,
  output logic              bitLast
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] txReg, txNext, rxReg;
  logic [BIT_W-1:0]  bitCnt;
  logic              nackReg;
  logic              sdaVal;

  always_comb begin
    if (stb.loadTx)          txNext = cmdData;
    else if (stb.loadAddr)   txNext = {cmdData[BYTE_W-2:0], cmdRead};
    else if (stb.loadAckOut) txNext = {nackReg, {(BYTE_W-1){1'b0}}};
    else if (stb.txShift)    txNext = {txReg[BYTE_W-2:0], 1'b0};
    else                     txNext = txReg;
    case (stb.sdaSrc)
      SRC_ONE: sdaVal = 1'b1;
      SRC_TX:  sdaVal = txNext[BYTE_W-1];
      default: sdaVal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scl     <= 1'b1;
      sdaOe   <= 1'b0;
      sdaOut  <= 1'b0;
      txReg   <= '0;
      rxReg   <= '0;
      nackReg <= 1'b0;
      ackErr  <= 1'b0;
      bitCnt  <= '0;
    end else begin
      txReg <= txNext;
      if (stb.sclRise)      scl <= 1'b1;
      else if (stb.sclFall) scl <= 1'b0;
      if (stb.sdaDrv) begin
        sdaOe  <= 1'b1;
        sdaOut <= sdaVal;
      end else if (stb.sdaRel) begin
        sdaOe  <= 1'b0;
        sdaOut <= 1'b0;
      end
      if (stb.armRx) begin
        rxReg   <= '0;
        nackReg <= cmdLast;
      end else if (stb.rxSample) begin
        rxReg <= {rxReg[BYTE_W-2:0], sdaIn};
      end
      if (stb.ackSample) ackErr <= sdaIn;
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign rxByte  = rxReg;
  assign bitLast = (bitCnt == BIT_W'(BYTE_W - 1));

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  input  logic            expired,
  input  logic            bitLast,
  output strobe_t         stb,
  output logic            tmrLoad,
  output wait_e           tmrSel,
  output logic            busy,
  output logic            done
);

  typedef enum logic [3:0] {
    S_IDLE, S_ST_SETUP, S_ST_HOLD, S_ST_LOW, S_SP_LOW, S_SP_HIGH, S_SP_IDLE,
    S_TX_SETUP, S_TX_HIGH, S_TX_LOW, S_RX_REL, S_RX_HIGH, S_RX_LOW
  } state_e;

  state_e state, nxt;
  logic   ackPhase, ackNxt, fin;

  always_comb begin
    stb     = '0;
    tmrLoad = 1'b0;
    tmrSel  = W_LOW;
    nxt     = state;
    ackNxt  = ackPhase;
    fin     = 1'b0;
    case (state)
      S_IDLE: if (cmdValid) begin
        case (cmdOp)
          OP_START: begin
            stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_ONE; stb.sclRise = 1'b1;
            tmrLoad = 1'b1; tmrSel = W_SSETUP; nxt = S_ST_SETUP;
          end
          OP_STOP: begin
            stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_ZERO;
            tmrLoad = 1'b1; tmrSel = W_C2D; nxt = S_SP_LOW;
          end
          OP_SEND, OP_ADDR: begin
            stb.loadTx   = (cmdOp == OP_SEND);
            stb.loadAddr = (cmdOp == OP_ADDR);
            stb.cntClr = 1'b1; stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_TX;
            tmrLoad = 1'b1; tmrSel = W_SETUP; nxt = S_TX_SETUP; ackNxt = 1'b0;
          end
          OP_RECV: begin
            stb.armRx = 1'b1; stb.cntClr = 1'b1; stb.sdaRel = 1'b1;
            tmrLoad = 1'b1; tmrSel = W_C2D; nxt = S_RX_REL; ackNxt = 1'b0;
          end
          default: ;
        endcase
      end
      S_ST_SETUP: if (expired) begin
        stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_ZERO;
        tmrLoad = 1'b1; tmrSel = W_SHOLD; nxt = S_ST_HOLD;
      end
      S_ST_HOLD: if (expired) begin
        stb.sclFall = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_LOW; nxt = S_ST_LOW;
      end
      S_SP_LOW: if (expired) begin
        stb.sclRise = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_PSETUP; nxt = S_SP_HIGH;
      end
      S_SP_HIGH: if (expired) begin
        stb.sdaRel = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_IDLE; nxt = S_SP_IDLE;
      end
      S_ST_LOW, S_SP_IDLE: if (expired) begin
        fin = 1'b1; nxt = S_IDLE;
      end
      S_TX_SETUP: if (expired) begin
        stb.sclRise = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_HIGH; nxt = S_TX_HIGH;
      end
      S_TX_HIGH: if (expired) begin
        stb.sclFall = 1'b1; stb.sdaRel = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_LOW; nxt = S_TX_LOW;
      end
      S_TX_LOW: if (expired) begin
        if (ackPhase) begin
          fin = 1'b1; nxt = S_IDLE;
        end else if (!bitLast) begin
          stb.txShift = 1'b1; stb.cntInc = 1'b1;
          stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_TX;
          tmrLoad = 1'b1; tmrSel = W_SETUP; nxt = S_TX_SETUP;
        end else begin
          ackNxt = 1'b1; stb.sdaRel = 1'b1;
          tmrLoad = 1'b1; tmrSel = W_C2D; nxt = S_RX_REL;
        end
      end
      S_RX_REL: if (expired) begin
        stb.sclRise = 1'b1;
        tmrLoad = 1'b1; tmrSel = W_HIGH; nxt = S_RX_HIGH;
      end
      S_RX_HIGH: if (expired) begin
        stb.sclFall   = 1'b1;
        stb.ackSample = ackPhase;
        stb.rxSample  = !ackPhase;
        tmrLoad = 1'b1; tmrSel = W_RXLOW; nxt = S_RX_LOW;
      end
      S_RX_LOW: if (expired) begin
        if (ackPhase) begin
          fin = 1'b1; nxt = S_IDLE;
        end else if (!bitLast) begin
          stb.cntInc = 1'b1; stb.sdaRel = 1'b1;
          tmrLoad = 1'b1; tmrSel = W_C2D; nxt = S_RX_REL;
        end else begin
          stb.loadAckOut = 1'b1; ackNxt = 1'b1;
          stb.sdaDrv = 1'b1; stb.sdaSrc = SRC_TX;
          tmrLoad = 1'b1; tmrSel = W_SETUP; nxt = S_TX_SETUP;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      ackPhase <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      ackPhase <= ackNxt;
      done     <= fin;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/i2cBitMaster.sv
module i2cBitMaster
  import i2cm_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = 16,
  parameter int OP_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastMode,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdRead,
  input  logic              cmdLast,
  input  logic              sdaIn,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxByte,
  output logic              ackErr,
  output logic              scl,
  output logic              sdaOe,
  output logic              sdaOut
);

  strobe_t stb;
  logic    tmrLoad, expired, bitLast;
  wait_e   tmrSel;

  i2cm_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .expired(expired), .bitLast(bitLast), .stb(stb),
    .tmrLoad(tmrLoad), .tmrSel(tmrSel), .busy(busy), .done(done)
  );

  i2cm_timer #(.TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rstN(rstN), .load(tmrLoad), .sel(tmrSel),
    .fastMode(fastMode), .expired(expired)
  );

  i2cm_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdData(cmdData),
    .cmdRead(cmdRead), .cmdLast(cmdLast), .sdaIn(sdaIn),
    .scl(scl), .sdaOe(sdaOe), .sdaOut(sdaOut), .rxByte(rxByte),
    .ackErr(ackErr), .bitLast(bitLast)
  );

endmodule

// File: rtl/i2cBitMaster_chk.sv
module i2cBitMaster_chk
  import i2cm_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int CNT_W       = 16,
  parameter int OP_W        = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [OP_W-1:0] cmdOp,
  input logic            busy,
  input logic            done,
  input logic            scl,
  input logic            sdaOe,
  input logic            sdaOut
);

  localparam int MIN_HIGH = nsToTicks(FAST_HIGH_NS) * TICK_CYCLES;

  logic             lvl, prevLvl, prevScl, startFlag;
  logic [CNT_W-1:0] hiCnt;

  assign lvl = !sdaOe || sdaOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl   <= 1'b1;
      prevScl   <= 1'b1;
      startFlag <= 1'b0;
      hiCnt     <= '0;
    end else begin
      prevLvl <= lvl;
      prevScl <= scl;
      if (scl && prevScl && prevLvl && !lvl) startFlag <= 1'b1;
      else if (!scl)                         startFlag <= 1'b0;
      if (!scl)             hiCnt <= '0;
      else if (hiCnt != '1) hiCnt <= hiCnt + 1'b1;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r9_accept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && (cmdOp <= OP_W'(4))) |=> busy);
  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && (cmdOp > OP_W'(4))) |=> !busy);
  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(scl) && !startFlag) |-> !sdaOe);
  a_r3_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl) && !$past(lvl) && lvl) |-> !sdaOe);
  a_r8_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scl) |-> (hiCnt >= CNT_W'(MIN_HIGH)));

endmodule

bind i2cBitMaster i2cBitMaster_chk #(
  .TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W), .OP_W(OP_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .busy(busy), .done(done), .scl(scl), .sdaOe(sdaOe), .sdaOut(sdaOut)
);

// File: tb/i2cBitMaster_tb_top.sv
module i2cBitMaster_tb_top;

  localparam int TCK = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fastMode = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic       cmdRead = 1'b0;
  logic       cmdLast = 1'b0;
  logic       busy, done, ackErr, scl, sdaOe, sdaOut;
  logic [7:0] rxByte;
  logic       line, slaveBit;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // target model state
  logic [8:0] slavePat = '1;
  int         bitIdx = 0;
  logic [8:0] capBits;
  int         capCnt, hiCnt, lastHigh, holdCnt, holdW;
  bit         holding, stopSeen, relOk;
  logic       prevScl = 1'b1, prevLine = 1'b1;

  typedef struct {
    int         op;
    logic [7:0] data;
    logic       ack;
    logic       last;
    int         highCyc;
    int         holdCyc;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  assign slaveBit = (bitIdx < 9) ? slavePat[8 - bitIdx] : 1'b1;
  assign line     = (sdaOe ? sdaOut : 1'b1) & slaveBit;

  i2cBitMaster dut_i (
    .clk(clk), .rstN(rstN), .fastMode(fastMode), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .cmdRead(cmdRead), .cmdLast(cmdLast),
    .sdaIn(line), .busy(busy), .done(done), .rxByte(rxByte), .ackErr(ackErr),
    .scl(scl), .sdaOe(sdaOe), .sdaOut(sdaOut)
  );

  function automatic int cyc(input int ns);
    return ((ns * 125) / 10000) * TCK;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    if (prevScl && !scl) begin
      bitIdx++;
      lastHigh = hiCnt;
      if (sdaOe) relOk = 0;
      if (holding) begin holdW = holdCnt; holding = 0; end
    end
    if (!prevScl && scl) begin
      capBits = {capBits[7:0], line};
      capCnt++;
    end
    hiCnt = scl ? hiCnt + 1 : 0;
    if (scl && prevScl && prevLine && !line) begin holding = 1; holdCnt = 1; end
    else if (holding && scl) holdCnt++;
    if (scl && prevScl && !prevLine && line) stopSeen = 1;
    prevScl  = scl;
    prevLine = line;
    if (done && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      case (e.op)
        0: begin
          chk("R2 start hold cycles", holdW, e.holdCyc);
          chk("R2 scl low after start", scl, 0);
          chk("R2 sda held low after start", {sdaOe, sdaOut}, 2'b10);
        end
        1: begin
          chk("R3 sda released while scl high", stopSeen, 1);
          chk("R3 final lines", {scl, sdaOe}, 2'b10);
        end
        2, 4: begin
          chk(e.op == 4 ? "R7 address byte on wire" : "R4 data byte on wire",
              capBits[8:1], e.data);
          chk("R4 ninth clock count", capCnt, 9);
          chk("R4 ackErr", ackErr, e.ack);
          chk("R8 clock high cycles", lastHigh, e.highCyc);
          chk("R5 release on scl fall", relOk, 1);
        end
        default: begin
          chk("R6 received byte", rxByte, e.data);
          chk("R6 master ack bit", capBits[0], e.last);
          chk("R8 clock high cycles", lastHigh, e.highCyc);
          chk("R5 release on scl fall", relOk, 1);
        end
      endcase
    end
  end

  task automatic doCmd(input int op, input logic [7:0] data, input logic rd,
                       input logic last, input logic [8:0] pat, input logic fast,
                       input logic [7:0] expData, input logic expAck,
                       input bit inject);
    exp_t e;
    @(negedge clk);
    slavePat = pat; bitIdx = 0; capBits = '0; capCnt = 0;
    stopSeen = 0; relOk = 1; holdW = 0; holding = 0;
    e.op = op; e.data = expData; e.ack = expAck; e.last = last;
    e.highCyc = cyc(fast ? 600 : 4000);
    e.holdCyc = cyc(fast ? 600 : 4000);
    sbq.push_back(e);
    fastMode = fast; cmdOp = 3'(op); cmdData = data; cmdRead = rd; cmdLast = last;
    cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    chk("R9 busy after accept", busy, 1);
    if (inject) begin
      repeat (300) @(negedge clk);
      cmdOp = 3'd2; cmdData = ~data; cmdValid = 1;
      @(negedge clk);
      cmdValid = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset scl", scl, 1);
    chk("R1 reset sdaOe", sdaOe, 0);
    chk("R1 reset busy", busy, 0);

    // fast mode transactions (R11 fast set)
    doCmd(0, 8'h00, 0, 0, 9'h1FF, 1, 8'h00, 0, 0);
    doCmd(4, 8'h50, 0, 0, 9'h1FE, 1, 8'hA0, 0, 0);   // write address, ACK
    doCmd(2, 8'hA5, 0, 0, 9'h1FF, 1, 8'hA5, 1, 0);   // NACK -> ackErr 1
    doCmd(2, 8'h3C, 0, 0, 9'h1FE, 1, 8'h3C, 0, 1);   // R9 injected cmd ignored
    doCmd(0, 8'h00, 0, 0, 9'h1FF, 1, 8'h00, 0, 0);   // repeated start
    doCmd(4, 8'h50, 1, 0, 9'h1FE, 1, 8'hA1, 0, 0);   // read address
    doCmd(3, 8'h00, 0, 0, {8'h96, 1'b1}, 1, 8'h96, 0, 0);
    doCmd(3, 8'h00, 0, 1, {8'h5A, 1'b1}, 1, 8'h5A, 0, 0);
    doCmd(1, 8'h00, 0, 0, 9'h1FF, 1, 8'h00, 0, 0);

    // R10 unused code
    @(negedge clk);
    cmdOp = 3'd6; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    chk("R10 unused op not busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R10 lines unchanged", {scl, sdaOe, done}, 3'b100);

    // standard timing set (R11, R8)
    doCmd(0, 8'h00, 0, 0, 9'h1FF, 0, 8'h00, 0, 0);
    doCmd(2, 8'hC3, 0, 0, 9'h1FE, 0, 8'hC3, 0, 0);
    doCmd(1, 8'h00, 0, 0, 9'h1FF, 0, 8'h00, 0, 0);

    repeat (5) @(negedge clk);
    chk("R9 scoreboard drained", sbq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule